// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Posted Store Queue

This block is a 2 KB data cache for a 32-bit byte-addressed processor. It keeps 64 lines of 32 bytes each; every line carries a valid flag and a 21-bit tag. Reads that find their line answer from the cache. Reads that miss bring the whole line in from a simple memory port as eight 32-bit beats, then answer. Stores are write-through and no-write-allocate: a store that finds its line updates that word, and every store, hit or miss, is posted into a four-entry first-in first-out queue. A drain engine sends queued stores to memory one at a time in the background.

The processor side uses a valid/ready request with a one-cycle response pulse for reads. Stores get no response; acceptance completes them. The processor stalls only when a store meets a full queue, or when a read miss has to wait for the queue to empty before its line fill. Because the queue is empty whenever a fill starts, a fill can never return a value older than a store that was accepted before it.

The control state machine has five states. IDLE accepts requests. LOOKUP compares tags for a read and gives the response on a hit. DRAIN waits for the store queue to empty after a miss. FILL_REQ issues one beat read. FILL_WAIT takes the beat data. The transitions are: IDLE to LOOKUP when a read is accepted; LOOKUP to IDLE on a hit; LOOKUP to DRAIN on a miss with stores queued; LOOKUP to FILL_REQ on a miss with the queue empty; DRAIN to FILL_REQ once the queue is empty; FILL_REQ to FILL_WAIT when memory takes the read; FILL_WAIT to FILL_REQ after a beat that is not the last; FILL_WAIT to LOOKUP after the last beat.

Top module: `wt_dcache`

## Requirements
- R1: Addresses are word-aligned, with bits 1:0 equal to 0. The address splits into a byte field in bits 4:0 (word select in bits 4:2), a line index in bits 10:5 and a tag in bits 31:11. A read whose line is valid with a matching tag is answered by a one-cycle `cpu_rsp_valid` pulse in the cycle right after acceptance, and it makes no memory request.
- R2: A read miss issues exactly eight memory reads (`mem_req_we`=0) at the line base plus 0, 4, 8 … 28, in ascending order. The response carries the requested word of the filled line.
- R3: A line becomes valid only when its last beat arrives. The read that caused the fill is answered right after that beat, and later reads of the same line hit.
- R4: A store that hits writes the word into the line and is also posted to memory. A later read returns the new value without a memory read, and memory ends up holding the value.
- R5: A store that misses does not fetch the line. A later read of that address still misses.
- R6: Queued stores reach memory as writes (`mem_req_we`=1) in the order the stores were accepted.
- R7: The queue holds four stores. While it is full, an offered store sees `cpu_req_ready` low until an entry drains.
- R8: A read miss issues no memory read while any store is still queued, so the fill returns the value of every earlier store.
- R9: Reset clears every valid flag and empties the queue. After reset there is no response and no memory request, and the first read misses.
- R10: Two addresses with the same index and different tags replace each other's line, so reading them alternately misses every time.
- R11: A memory request that is not taken keeps `mem_req_valid`, `mem_req_we`, its address and its data unchanged until `mem_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_we | input | 1 | 1 = store, 0 = read |
| cpu_req_addr | input | 32 | Word-aligned byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_ready | output | 1 | Request accepted at this edge when valid is high |
| cpu_rsp_valid | output | 1 | Read data valid (one cycle) |
| cpu_rsp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 = queued store write, 0 = fill beat read |
| mem_req_addr | output | 32 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Fill beat data valid |
| mem_rsp_rdata | input | 32 | Fill beat data |

## Verification
A wrong valid flag or tag shows up at the ports on the next read of that line. A false hit returns data in the cycle after acceptance with no memory reads, and a false miss starts a burst of eight reads. Either one is visible within a single cycle. A queue pointer error shows up as memory writes out of acceptance order, or as a ready that stays low with fewer than four stores pending. A fill that starts before the queue is empty shows up as a stale word returned right after a store to the same address.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DRAIN,
        ST_FILL_REQ,
        ST_FILL_WAIT
    } state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } store_entry_t;
endpackage

// File: rtl/wtc_post_queue.sv
module wtc_post_queue #(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  wtc_pkg::store_entry_t push_entry,
    input  logic                  pop,
    output wtc_pkg::store_entry_t head,
    output logic                  full,
    output logic                  empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wtc_pkg::store_entry_t slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_entry;
    end

    assign head  = slots[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    assert_push_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_pop_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int INDEX_W = 6,
    parameter int WSEL_W  = 3,
    parameter int TAG_W   = 21,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INDEX_W-1:0] rd_index,
    input  logic [WSEL_W-1:0]  rd_word,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [WSEL_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_set,
    input  logic [INDEX_W-1:0] tag_index,
    input  logic [TAG_W-1:0]  tag_value
);
    localparam int LINES = 1 << INDEX_W;
    localparam int WORDS = 1 << WSEL_W;

    logic [DATA_W-1:0] data_arr [LINES*WORDS];
    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [LINES-1:0]  valid_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) valid_bits <= '0;
        else if (tag_set) valid_bits[tag_index] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (tag_set) tag_arr[tag_index] <= tag_value;
        if (wr_en) data_arr[{wr_index, wr_word}] <= wr_data;
    end

    assign rd_valid = valid_bits[rd_index];
    assign rd_tag   = tag_arr[rd_index];
    assign rd_data  = data_arr[{rd_index, rd_word}];
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
    parameter int OFFSET_W    = 5,
    parameter int INDEX_W     = 6,
    parameter int QUEUE_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    input  logic        cpu_req_we,
    input  logic [31:0] cpu_req_addr,
    input  logic [31:0] cpu_req_wdata,
    output logic        cpu_req_ready,
    output logic        cpu_rsp_valid,
    output logic [31:0] cpu_rsp_rdata,
    output logic        mem_req_valid,
    output logic        mem_req_we,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata
);
    import wtc_pkg::*;

    localparam int WSEL_W = OFFSET_W - 2;
    localparam int TAG_W  = ADDR_W - INDEX_W - OFFSET_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = '1;

    state_t state, state_nxt;
    logic [ADDR_W-1:0] req_addr_q;
    logic [WSEL_W-1:0] beat_q;

    logic [ADDR_W-1:0] cur_addr;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_word;
    logic              hit;
    logic              accept, store_acc, read_acc;

    logic              q_push, q_pop, q_full, q_empty;
    store_entry_t      q_in, q_head;

    logic              arr_we;
    logic [INDEX_W-1:0] arr_windex;
    logic [WSEL_W-1:0]  arr_wword;
    logic [DATA_W-1:0]  arr_wdata;
    logic              tag_set;
    logic              drain_active;

    assign cur_addr = (state == ST_IDLE) ? cpu_req_addr : req_addr_q;
    assign hit = line_valid && (line_tag == cur_addr[ADDR_W-1 -: TAG_W]);

    wtc_line_store #(
        .INDEX_W (INDEX_W),
        .WSEL_W  (WSEL_W),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_index  (cur_addr[OFFSET_W +: INDEX_W]),
        .rd_word   (cur_addr[2 +: WSEL_W]),
        .rd_valid  (line_valid),
        .rd_tag    (line_tag),
        .rd_data   (line_word),
        .wr_en     (arr_we),
        .wr_index  (arr_windex),
        .wr_word   (arr_wword),
        .wr_data   (arr_wdata),
        .tag_set   (tag_set),
        .tag_index (req_addr_q[OFFSET_W +: INDEX_W]),
        .tag_value (req_addr_q[ADDR_W-1 -: TAG_W])
    );

    wtc_post_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .push_entry (q_in),
        .pop        (q_pop),
        .head       (q_head),
        .full       (q_full),
        .empty      (q_empty)
    );

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            req_addr_q <= '0;
            beat_q     <= '0;
        end else begin
            state <= state_nxt;
            if (read_acc) req_addr_q <= cpu_req_addr;
            if (state == ST_LOOKUP) beat_q <= '0;
            else if (state == ST_FILL_WAIT && mem_rsp_valid) beat_q <= beat_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (read_acc) state_nxt = ST_LOOKUP;
            ST_LOOKUP:    if (hit) state_nxt = ST_IDLE;
                          else if (q_empty) state_nxt = ST_FILL_REQ;
                          else state_nxt = ST_DRAIN;
            ST_DRAIN:     if (q_empty) state_nxt = ST_FILL_REQ;
            ST_FILL_REQ:  if (mem_req_ready) state_nxt = ST_FILL_WAIT;
            ST_FILL_WAIT: if (mem_rsp_valid)
                              state_nxt = (beat_q == LAST_BEAT) ? ST_LOOKUP : ST_FILL_REQ;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_req_ready = (state == ST_IDLE) && !(cpu_req_we && q_full);
        accept        = cpu_req_valid && cpu_req_ready;
        store_acc     = accept && cpu_req_we;
        read_acc      = accept && !cpu_req_we;

        cpu_rsp_valid = (state == ST_LOOKUP) && hit;
        cpu_rsp_rdata = line_word;

        q_push        = store_acc;
        q_in.addr     = cpu_req_addr;
        q_in.data     = cpu_req_wdata;

        arr_we        = 1'b0;
        arr_windex    = cpu_req_addr[OFFSET_W +: INDEX_W];
        arr_wword     = cpu_req_addr[2 +: WSEL_W];
        arr_wdata     = cpu_req_wdata;
        tag_set       = 1'b0;
        if (state == ST_FILL_WAIT) begin
            arr_we     = mem_rsp_valid;
            arr_windex = req_addr_q[OFFSET_W +: INDEX_W];
            arr_wword  = beat_q;
            arr_wdata  = mem_rsp_rdata;
            tag_set    = mem_rsp_valid && (beat_q == LAST_BEAT);
        end else if (store_acc && hit) begin
            arr_we     = 1'b1;
        end

        drain_active  = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        if (state == ST_FILL_REQ) begin
            mem_req_valid = 1'b1;
            mem_req_addr  = {req_addr_q[ADDR_W-1:OFFSET_W], beat_q, 2'b00};
        end else if (state != ST_FILL_WAIT && !q_empty) begin
            drain_active  = 1'b1;
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = q_head.addr;
            mem_req_wdata = q_head.data;
        end
        q_pop = drain_active && mem_req_ready;
    end

    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid || state != ST_IDLE) |-> cur_addr[1:0] == 2'b00);
    assert_single_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);
    assert_fill_ends_in_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && $past(state) == ST_FILL_WAIT) |-> cpu_rsp_valid);
    assert_fill_only_when_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> q_empty);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
endmodule

// File: tb/wt_dcache_tb.sv
module wt_dcache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_we = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_req_ready;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wt_dcache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    // ---------------- memory model ----------------
    logic [31:0] wmem [logic [31:0]];
    logic [31:0] rd_log [256];
    logic [31:0] wr_log [256];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int hold_err = 0;
    bit hold_ready = 0;
    bit slow = 0;
    bit rd_busy = 0;
    int rd_dly = 0;
    logic [31:0] rd_addr_q = '0;
    bit prev_stall = 0;
    logic [31:0] prev_addr = '0;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        if (wmem.exists(a)) return wmem[a];
        return a * 32'd3 + 32'h1234_0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_req_ready <= 1'b1;
            rd_busy = 0;
            prev_stall = 0;
        end else begin
            if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_err++;
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            mem_rsp_valid <= 1'b0;
            if (rd_busy) begin
                if (rd_dly == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_rdata <= mem_val(rd_addr_q);
                    rd_busy = 0;
                end else rd_dly--;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    wmem[mem_req_addr] = mem_req_wdata;
                    wr_log[wr_cnt % 256] = mem_req_addr;
                    wr_cnt++;
                end else begin
                    rd_log[rd_cnt % 256] = mem_req_addr;
                    rd_cnt++;
                    rd_busy = 1;
                    rd_dly = 2;
                    rd_addr_q = mem_req_addr;
                end
            end
            mem_req_ready <= hold_ready ? 1'b0 : (slow ? ~mem_req_ready : 1'b1);
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_we = 1; cpu_req_addr = a; cpu_req_wdata = d;
        #1;
        while (!cpu_req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 0;
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d, output int lat);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_we = 0; cpu_req_addr = a;
        #1;
        while (!cpu_req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        cpu_req_valid = 0;
        lat = 1;
        while (!cpu_rsp_valid) begin @(negedge clk); lat++; end
        d = cpu_rsp_rdata;
    endtask

    task automatic wait_drained();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (mem_req_valid || rd_busy) quiet = 0; else quiet++;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        @(negedge clk);
        chk(cpu_rsp_valid == 0, "R9 no response after reset", 32'(cpu_rsp_valid), 0);
        chk(mem_req_valid == 0, "R9 no memory request after reset", 32'(mem_req_valid), 0);
        chk(cpu_req_ready == 1, "R9 ready after reset", 32'(cpu_req_ready), 1);
    endtask

    task automatic t_cold_miss();
        logic [31:0] d; int lat; int r0 = rd_cnt; bit ord = 1;
        do_read(32'h0000_1048, d, lat);
        chk(rd_cnt - r0 == 8, "R2 R9 eight beat reads on cold miss", rd_cnt - r0, 8);
        for (int k = 0; k < 8; k++)
            if (rd_log[(r0 + k) % 256] != 32'h1040 + 32'(k * 4)) ord = 0;
        chk(ord, "R2 beat addresses ascending from line base", rd_log[r0 % 256], 32'h1040);
        chk(d == mem_val(32'h1048), "R2 requested word returned", d, mem_val(32'h1048));
    endtask

    task automatic t_hit();
        logic [31:0] d; int lat; int r0 = rd_cnt;
        do_read(32'h0000_105C, d, lat);
        chk(rd_cnt == r0, "R3 filled line hits with no memory read", rd_cnt - r0, 0);
        chk(lat == 1, "R1 hit answered one cycle after accept", lat, 1);
        chk(d == mem_val(32'h105C), "R1 hit data", d, mem_val(32'h105C));
    endtask

    task automatic t_store_hit();
        logic [31:0] d; int lat; int r0;
        do_store(32'h0000_1044, 32'hCAFE_0001);
        r0 = rd_cnt;
        do_read(32'h0000_1044, d, lat);
        chk(d == 32'hCAFE_0001, "R4 store hit updates line", d, 32'hCAFE_0001);
        chk(rd_cnt == r0, "R4 no memory read after store hit", rd_cnt - r0, 0);
        wait_drained();
        chk(wmem.exists(32'h1044) && wmem[32'h1044] == 32'hCAFE_0001, "R4 store written through",
            mem_val(32'h1044), 32'hCAFE_0001);
    endtask

    task automatic t_store_miss();
        logic [31:0] d; int lat; int r0 = rd_cnt;
        do_store(32'h0000_2000, 32'hBEEF_0002);
        wait_drained();
        chk(rd_cnt == r0, "R5 store miss fetches nothing", rd_cnt - r0, 0);
        do_read(32'h0000_2000, d, lat);
        chk(rd_cnt - r0 == 8, "R5 line not allocated by store", rd_cnt - r0, 8);
        chk(d == 32'hBEEF_0002, "R5 read after store miss", d, 32'hBEEF_0002);
    endtask

    task automatic t_conflict();
        logic [31:0] d; int lat; int r0 = rd_cnt;
        do_read(32'h0000_1848, d, lat);
        chk(rd_cnt - r0 == 8, "R10 same index new tag misses", rd_cnt - r0, 8);
        chk(d == mem_val(32'h1848), "R10 conflicting line data", d, mem_val(32'h1848));
        r0 = rd_cnt;
        do_read(32'h0000_1048, d, lat);
        chk(rd_cnt - r0 == 8, "R10 evicted line misses again", rd_cnt - r0, 8);
        chk(d == mem_val(32'h1048), "R10 refetched data", d, mem_val(32'h1048));
    endtask

    task automatic t_queue_full();
        logic [31:0] a [5] = '{32'h3000, 32'h3104, 32'h3208, 32'h330C, 32'h3410};
        int w0;
        bit stalled = 1;
        bit ord = 1;
        wait_drained();
        w0 = wr_cnt;
        hold_ready = 1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) do_store(a[i], 32'hD000_0000 + 32'(i));
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_we = 1; cpu_req_addr = a[4]; cpu_req_wdata = 32'hD000_0004;
        for (int i = 0; i < 3; i++) begin
            #1;
            if (cpu_req_ready) stalled = 0;
            @(negedge clk);
        end
        chk(stalled, "R7 fifth store stalls on full queue", 32'(!stalled), 0);
        hold_ready = 0;
        #1;
        while (!cpu_req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 0;
        wait_drained();
        chk(wr_cnt - w0 == 5, "R6 all five stores written", wr_cnt - w0, 5);
        for (int i = 0; i < 5; i++)
            if (wr_log[(w0 + i) % 256] != a[i]) ord = 0;
        chk(ord, "R6 writes in acceptance order", wr_log[(w0 + 4) % 256], a[4]);
    endtask

    task automatic t_stale_guard();
        logic [31:0] d; int lat; int r0; bit no_early = 1;
        wait_drained();
        hold_ready = 1;
        repeat (2) @(negedge clk);
        do_store(32'h0000_4010, 32'h5A5A_0003);
        r0 = rd_cnt;
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_we = 0; cpu_req_addr = 32'h4010;
        #1;
        while (!cpu_req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 0;
        for (int i = 0; i < 5; i++) begin
            if (cpu_rsp_valid || rd_cnt != r0) no_early = 0;
            @(negedge clk);
        end
        chk(no_early, "R8 no fill while store queued", rd_cnt - r0, 0);
        hold_ready = 0;
        while (!cpu_rsp_valid) @(negedge clk);
        d = cpu_rsp_rdata;
        lat = 0;
        chk(d == 32'h5A5A_0003, "R8 fill sees queued store", d, 32'h5A5A_0003);
    endtask

    task automatic t_slow_memory();
        logic [31:0] d; int lat;
        slow = 1;
        do_store(32'h0000_5004, 32'h7700_0001);
        do_store(32'h0000_5008, 32'h7700_0002);
        do_read(32'h0000_5008, d, lat);
        wait_drained();
        slow = 0;
        chk(d == 32'h7700_0002, "R11 data correct under stalls", d, 32'h7700_0002);
        chk(hold_err == 0, "R11 request held until taken", hold_err, 0);
    endtask

    task automatic t_reset_mid();
        logic [31:0] d; int lat; int r0;
        wait_drained();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        r0 = rd_cnt;
        do_read(32'h0000_105C, d, lat);
        chk(rd_cnt - r0 == 8, "R9 reset clears valid flags", rd_cnt - r0, 8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_cold_miss();
        t_hit();
        t_store_hit();
        t_store_miss();
        t_conflict();
        t_queue_full();
        t_stale_guard();
        t_slow_memory();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule